// File: doc/BRIEF.md
# Oversampled Phase-Picking Data Recovery

This block recovers a serial bit stream from words of raw samples that a free-running sampler array took at three times the bit rate. Each accepted word carries 24 samples, that is eight bit slots of three phases each. The block looks for level changes between neighbouring samples and tallies them per sampling phase over a window of words. At the end of each window it moves its pick point to the phase one step after the busiest edge phase, which places it near the centre of the eye. It then takes one sample per bit slot. Neither the sampling clock nor the data is delayed, so the residual placement error stays within half a unit interval divided by three.

When the pick point wraps across a slot boundary, the word that follows gives one bit more or one bit fewer than eight. A shifting output buffer collects the recovered bits in time order and releases them as 8-bit words, each with a one-cycle valid strobe. No acquisition period is needed: the first word already yields data.

Top module: `os_pick_rx`

## Requirements
- R1: A synchronous reset drops out_vld, empties the bit buffer and the edge tallies, sets the picked phase to 1, sets the remembered previous sample to 0, and clears any pending wrap correction.
- R2: Sample in_smp[3*b+p] is phase p (0, 1 or 2) of bit slot b, and index 0 is the earliest in time. An edge is seen at index k when sample k differs from sample k-1, and at index 0 the comparison uses the last sample of the previous accepted word. The edge counts towards phase k mod 3. Counts are summed over WIN accepted words. The picked phase changes only after the WIN-th word, and it applies from the next accepted word on.
- R3: The new phase is (phase with the most edges + 1) mod 3. On a tie the lowest phase number wins. A window with no edges at all leaves the phase unchanged.
- R4: Each accepted word gives the sample at the picked phase of every slot, in time order. Without a wrap that is exactly 8 bits, and the earliest bit lands in out_word[0].
- R5: After a change from phase 0 to phase 2, the next accepted word gives 9 bits: first the last sample of the previous word, then its 8 picks.
- R6: After a change from phase 2 to phase 0, the next accepted word skips its sample 0 and gives 7 bits.
- R7: out_vld pulses for one cycle for each 8 collected bits, and out_word then holds the next 8 bits in order. At most one word leaves per cycle. Words keep leaving on cycles without input while 8 or more bits are held, and nothing leaves while fewer than 8 are held.
- R8: Under a slow rate offset between sender and sampler, and at any starting offset, the output stream equals the sent stream from the first word on, with no bit lost or repeated.
- R9: While in_vld is low the samples are ignored: phase, tallies and buffer contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | in_smp holds a new sample word |
| in_smp | input | 3*BITS | Raw samples, index 0 earliest, three per bit slot |
| out_vld | output | 1 | out_word holds a recovered word this cycle |
| out_word | output | BITS | Recovered bits, earliest in bit 0 |

## Verification
Constant and periodic sample words with edges at a single known phase make each decision step visible in the output. A word that has ones only at one phase shows which phase was picked. A probe placed just before and just after a window boundary shows when the decision takes effect. Edge patterns that tie, or words with no edges, check the priority and hold rules. Wrap cases in both directions are checked through the exact bit that is added or dropped. Pseudo-random streams sampled with rate offsets of both signs and at several starting offsets, with random data on idle cycles, show that slips are resolved without losing or repeating a bit.

// File: rtl/os_pick_rx.sv
module os_pick_rx #(
  parameter int BITS = 8,
  parameter int WIN  = 4,
  parameter int BUFW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [3*BITS-1:0] in_smp,
  output logic              out_vld,
  output logic [BITS-1:0]   out_word
);
  localparam int NS = 3 * BITS;
  localparam int AW = $clog2(BITS * WIN + 1);
  localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int CW = $clog2(BUFW + 1);
  localparam logic [1:0] ADJ_NONE = 2'd0;
  localparam logic [1:0] ADJ_GAIN = 2'd1;
  localparam logic [1:0] ADJ_LOSE = 2'd2;

  logic [1:0]      sel_q, adj_q;
  logic            last_q;
  logic [WW-1:0]   wc_q;
  logic [AW-1:0]   acc_q [3];
  logic [BUFW-1:0] buf_q;
  logic [CW-1:0]   cnt_q;

  logic [NS-1:0] edg;
  assign edg = in_smp ^ {in_smp[NS-2:0], last_q};

  logic [AW-1:0] tot [3];
  always_comb begin
    for (int p = 0; p < 3; p++) begin
      tot[p] = acc_q[p];
      for (int b = 0; b < BITS; b++)
        tot[p] = tot[p] + AW'(edg[3*b+p]);
    end
  end

  logic [1:0] mx, nsel, nadj;
  logic       any_e, wend;
  always_comb begin
    mx = 2'd0;
    if (tot[1] > tot[0]) mx = 2'd1;
    if (tot[2] > tot[mx]) mx = 2'd2;
  end
  assign any_e = (tot[0] | tot[1] | tot[2]) != '0;
  assign nsel  = !any_e ? sel_q : (mx == 2'd2) ? 2'd0 : mx + 2'd1;
  assign wend  = in_vld && (wc_q == WW'(WIN - 1));
  assign nadj  = (sel_q == 2'd0 && nsel == 2'd2) ? ADJ_GAIN :
                 (sel_q == 2'd2 && nsel == 2'd0) ? ADJ_LOSE : ADJ_NONE;

  logic [BITS-1:0] pk;
  always_comb begin
    for (int b = 0; b < BITS; b++)
      pk[b] = (sel_q == 2'd0) ? in_smp[3*b] :
              (sel_q == 2'd1) ? in_smp[3*b+1] : in_smp[3*b+2];
  end

  logic [BITS:0] nb;
  logic [CW-1:0] nn;
  always_comb begin
    case (adj_q)
      ADJ_GAIN: begin nb = {pk, last_q};        nn = CW'(BITS + 1); end
      ADJ_LOSE: begin nb = {2'b00, pk[BITS-1:1]}; nn = CW'(BITS - 1); end
      default:  begin nb = {1'b0, pk};          nn = CW'(BITS);     end
    endcase
  end

  logic [CW:0]     ncnt;
  logic [BUFW-1:0] merged;
  logic            emit;
  assign ncnt   = {1'b0, cnt_q} + (in_vld ? {1'b0, nn} : '0);
  assign merged = buf_q | (in_vld ? (BUFW'(nb) << cnt_q) : '0);
  assign emit   = ncnt >= (CW+1)'(BITS);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= 2'd1;
      adj_q    <= ADJ_NONE;
      last_q   <= 1'b0;
      wc_q     <= '0;
      for (int p = 0; p < 3; p++) acc_q[p] <= '0;
      buf_q    <= '0;
      cnt_q    <= '0;
      out_vld  <= 1'b0;
      out_word <= '0;
    end else begin
      out_vld <= emit;
      if (emit) out_word <= merged[BITS-1:0];
      buf_q <= emit ? (merged >> BITS) : merged;
      cnt_q <= emit ? CW'(ncnt - (CW+1)'(BITS)) : CW'(ncnt);
      if (in_vld) begin
        last_q <= in_smp[NS-1];
        adj_q  <= wend ? nadj : ADJ_NONE;
        if (wend) begin
          sel_q <= nsel;
          wc_q  <= '0;
          for (int p = 0; p < 3; p++) acc_q[p] <= '0;
        end else begin
          wc_q <= wc_q + WW'(1);
          for (int p = 0; p < 3; p++) acc_q[p] <= tot[p];
        end
      end
    end
  end
endmodule

// File: rtl/os_pick_rx_chk.sv
module os_pick_rx_chk #(
  parameter int BITS = 8,
  parameter int BUFW = 32,
  parameter int CW   = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          in_vld,
  input logic          out_vld,
  input logic [1:0]    sel_q,
  input logic [1:0]    adj_q,
  input logic [CW-1:0] cnt_q
);
  logic rst_d = 1'b0;
  always @(posedge clk) begin
    rst_d <= rst;
    // R1
    if (rst_d && !rst)
      rst_state_chk: assert (sel_q == 2'd1 && cnt_q == '0 && !out_vld && adj_q == 2'd0);
  end

  // R3
  sel_legal_chk: assert property (@(posedge clk) disable iff (rst) sel_q != 2'd3);

  // R9
  sel_idle_chk: assert property (@(posedge clk) disable iff (rst) !in_vld |=> $stable(sel_q));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_vld && cnt_q < CW'(BITS)) |=> (!out_vld && $stable(cnt_q)));

  // R7
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_vld && cnt_q >= CW'(BITS)) |=> out_vld);

  // R7
  buf_room_chk: assert property (@(posedge clk) disable iff (rst) cnt_q <= CW'(BUFW));

  // R5
  gain_phase_chk: assert property (@(posedge clk) disable iff (rst) (adj_q == 2'd1) |-> sel_q == 2'd2);

  // R6
  lose_phase_chk: assert property (@(posedge clk) disable iff (rst) (adj_q == 2'd2) |-> sel_q == 2'd0);
endmodule

bind os_pick_rx os_pick_rx_chk #(.BITS(BITS), .BUFW(BUFW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .out_vld(out_vld),
  .sel_q(sel_q), .adj_q(adj_q), .cnt_q(cnt_q)
);

// File: tb/test_os_pick_rx.sv
module test_os_pick_rx;
  localparam int BITS  = 8;
  localparam int NS    = 3 * BITS;
  localparam int SCALE = 1024;
  localparam int NW    = 100;
  localparam int NSC   = 6;
  localparam int SC_DELTA [NSC] = '{0, 0, 5, -5, 9, -9};
  localparam int SC_OFF   [NSC] = '{0, 1700, 400, 2500, 1100, 3000};

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_vld = 1'b0;
  logic [NS-1:0]   in_smp = '0;
  logic            out_vld;
  logic [BITS-1:0] out_word;

  always #2 clk = ~clk;

  os_pick_rx #(.BITS(BITS), .WIN(4), .BUFW(32)) i_os_pick_rx (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_smp(in_smp),
    .out_vld(out_vld), .out_word(out_word)
  );

  int nrun = 0, nfail = 0, nout = 0;
  bit stream_on = 1'b0;
  longint per_v = 3 * SCALE, off_v = 0, exp_ptr = 0;
  logic [BITS-1:0] cap [64];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit txbit(input longint i);
    logic [31:0] x;
    x = 32'(i) * 32'h9E3779B1;
    return x[15] ^ x[22] ^ x[28];
  endfunction

  function automatic bit smp_at(input longint n);
    return txbit((n * SCALE + off_v) / per_v);
  endfunction

  function automatic logic [NS-1:0] pat_edge(input int p);
    logic [NS-1:0] v;
    for (int k = 0; k < NS; k++) v[k] = ((((k + 3 - p) / 3) % 2) == 1);
    return v;
  endfunction

  function automatic logic [NS-1:0] pat_ones(input int q);
    logic [NS-1:0] v;
    for (int k = 0; k < NS; k++) v[k] = ((k % 3) == q);
    return v;
  endfunction

  always @(negedge clk) begin
    if (!rst && out_vld) begin
      logic [BITS-1:0] ew;
      if (nout < 64) cap[nout] = out_word;
      if (stream_on) begin
        for (int j = 0; j < BITS; j++) ew[j] = txbit(exp_ptr + j);
        check("R8/R9 recovered stream word", 32'(out_word), 32'(ew));
        exp_ptr += BITS;
      end
      nout++;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_vld = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 out_vld in reset", 32'(out_vld), 32'd0);
    rst = 1'b0;
    nout = 0;
  endtask

  task automatic put(input logic [NS-1:0] w);
    @(negedge clk);
    in_vld = 1'b1; in_smp = w;
    @(negedge clk);
    in_vld = 1'b0; in_smp = NS'($urandom);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    nfail++;
    $display("FAIL watchdog R8: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSC; s++) begin
      do_reset();
      per_v = 3 * SCALE + SC_DELTA[s];
      off_v = SC_OFF[s];
      exp_ptr = (SCALE + off_v) / per_v;
      stream_on = 1'b1;
      for (int w = 0; w < NW; w++) begin
        logic [NS-1:0] word;
        for (int k = 0; k < NS; k++) word[k] = smp_at(longint'(w) * NS + k);
        put(word);
      end
      idle(4);
      stream_on = 1'b0;
      check("R8 word count near input count", 32'(nout >= NW - 2 && nout <= NW + 2), 32'd1);
    end

    do_reset();
    for (int i = 0; i < 4; i++) put('0);
    put(pat_ones(1));
    idle(3);
    check("R4 words from zero input", 32'(nout), 32'd5);
    for (int i = 0; i < 4; i++) check("R4 zero input word", 32'(cap[i]), 32'h00);
    check("R3 no edges keeps phase 1", 32'(cap[4]), 32'hFF);

    do_reset();
    for (int i = 0; i < 3; i++) put(pat_edge(2));
    put(pat_ones(1));
    put(pat_ones(0));
    idle(3);
    for (int i = 0; i < 3; i++) check("R4 picks phase 1 in time order", 32'(cap[i]), 32'hAA);
    check("R2 phase held until window end", 32'(cap[3]), 32'hFF);
    check("R3 edges at phase 2 pick phase 0", 32'(cap[4]), 32'hFF);

    do_reset();
    for (int i = 0; i < 4; i++) put(pat_ones(0));
    put(pat_ones(1));
    idle(3);
    check("R3 tie word before decision", 32'(cap[0]), 32'h00);
    check("R3 tie resolves to lowest phase", 32'(cap[4]), 32'hFF);

    do_reset();
    for (int i = 0; i < 4; i++) put(pat_edge(2));
    for (int i = 0; i < 4; i++) put(pat_edge(1));
    put(pat_ones(2));
    put('0);
    idle(3);
    check("R5 gain word count", 32'(nout), 32'd10);
    check("R5 extra bit first", 32'(cap[8]), 32'hFE);
    check("R5 carried bit", 32'(cap[9]), 32'h01);

    do_reset();
    for (int i = 0; i < 4; i++) put(pat_edge(1));
    for (int i = 0; i < 4; i++) put(pat_edge(2));
    put(pat_ones(0));
    idle(2);
    check("R7 no word from 7 held bits", 32'(nout), 32'd8);
    put('0);
    put('0);
    put('0);
    idle(3);
    check("R6 dropped sample 0", 32'(cap[8]), 32'h7F);
    check("R6 R7 lose word count", 32'(nout), 32'd11);

    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule